// File: doc/BRIEF.md
# Load Base-Address Shadow Broadcaster

This block coordinates a small pool of load function units for a vector load whose base address lives in a scalar register. Element loads are issued as they arrive. Decode never waits for the base register. Each issued element takes a free unit and is held under an address-wait shadow until the base value shows up on the register-read result port. That value is captured once in a holding register. In the same cycle it is broadcast to every unit still waiting, and each of those units forms its own element address.

Every unit also holds a separate exception shadow. It stays up until the memory side confirms the access for that unit, no matter when the address arrived. A unit drives its memory request only once its address is known and either the access is confirmed or speculative access is enabled for the current vector.

If a unit reports a fault, the block reports the oldest faulting element. It cancels that element and every younger one in flight, and it accepts no further elements until the next vector begins. The pool is small, so a long vector streams through it: issue is refused while every unit is occupied.

Top module: `ld_base_bcast`

## Requirements
- R1: After reset, no unit is busy, no shadow or request is raised, no fault is reported, and `issue_ready_o` is high.
- R2: An element accepted before the base value is known occupies a unit with both shadows set and no request. While a free unit remains, issue stays ready.
- R3: The first `base_valid_i` of a vector clears the address-wait shadow of every waiting unit in the next cycle. Each such unit's address becomes base + index × 2^size, where size code 0/1/2/3 means 1/2/4/8-byte elements.
- R4: A unit's exception shadow stays set after the broadcast. It clears only when `mem_ok_i` for that unit arrives while its address is known.
- R5: `unit_req_o[k]` is high exactly when unit k is busy, its address is known, and either its exception shadow is clear or the vector was started with speculation enabled.
- R6: An element accepted in the same cycle as, or after, the base capture gets a clear address-wait shadow and its final address in the next cycle.
- R7: Any further `base_valid_i` within the same vector is ignored. Addresses keep using the first captured base.
- R8: With all units busy, `issue_ready_o` is low and no element is accepted.
- R9: An accepted element goes to the lowest-numbered free unit.
- R10: A fault on a busy unit with a known address is reported the next cycle through `fault_valid_o` (a one-cycle pulse) and `fault_idx_o`, which gives the lowest faulting element index. That element and every busy element with a higher index are freed, older ones stay, and issue is refused until `vec_start_i`.
- R11: `retire_i` for a unit whose exception shadow is still set is ignored and the unit stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_start_i | input | 1 | Begin a new vector load; frees all units and forgets the base |
| vec_size_i | input | 2 | Element size code for the new vector (0:1B 1:2B 2:4B 3:8B) |
| vec_spec_i | input | 1 | Allow requests before access confirmation for the new vector |
| issue_valid_i | input | 1 | Element offered for issue |
| issue_idx_i | input | IDX_W | Element index within the vector |
| issue_ready_o | output | 1 | Element accepted this cycle when valid |
| base_valid_i | input | 1 | Base register value delivered |
| base_addr_i | input | ADDR_W | Base register value |
| mem_ok_i | input | NUM_UNITS | Per unit: memory access confirmed |
| retire_i | input | NUM_UNITS | Per unit: element complete, free the unit |
| fault_i | input | NUM_UNITS | Per unit: access raised an exception |
| unit_busy_o | output | NUM_UNITS | Unit holds an element |
| unit_aw_o | output | NUM_UNITS | Address-wait shadow per unit |
| unit_ex_o | output | NUM_UNITS | Exception shadow per unit |
| unit_req_o | output | NUM_UNITS | Memory request per unit |
| unit_addr_o | output | NUM_UNITS*ADDR_W | Element address per unit |
| unit_idx_o | output | NUM_UNITS*IDX_W | Element index per unit |
| fault_valid_o | output | 1 | Fault report pulse |
| fault_idx_o | output | IDX_W | Oldest faulting element index |

## Verification
The bench builds the block with four units, a 32-bit address and 6-bit element indices. Vectors of up to 12 elements therefore overrun the pool and make issue wait on retirement. Random base arrival gives broadcasts to anywhere from zero to four waiting units, elements issued after capture, and repeated base deliveries. All four size codes and both speculation settings appear, along with faults that hit several units at once, so both the oldest-pick and the younger-cancel paths are reached.

// File: rtl/lbb_pkg.sv
package lbb_pkg;
  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2,
    ESZ_DBL  = 2'd3
  } esize_e;
endpackage

// File: rtl/lbb_pick_low.sv
module lbb_pick_low #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    any_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && !any_o) begin
        gnt_o[k] = 1'b1;
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbb_oldest.sv
module lbb_oldest #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 6
) (
  input  logic [N-1:0]       hit_i,
  input  logic [N*IDX_W-1:0] idx_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (hit_i[k] && (!any_o || idx_i[k*IDX_W +: IDX_W] < idx_o)) begin
        any_o = 1'b1;
        idx_o = idx_i[k*IDX_W +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/lbb_unit.sv
module lbb_unit
  import lbb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  esize_e            size_i,
  input  logic              base_known_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              bcast_i,
  input  logic              mem_ok_i,
  input  logic              retire_i,
  input  logic              kill_i,
  input  logic              spec_i,
  output logic              busy_o,
  output logic              aw_o,
  output logic              ex_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic              busy_q, aw_q, ex_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] off_new, off_old;

  assign off_new = ADDR_W'(idx_i) << size_i;
  assign off_old = ADDR_W'(idx_q) << size_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      aw_q   <= 1'b0;
      ex_q   <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
    end else if (kill_i) begin
      busy_q <= 1'b0;
      aw_q   <= 1'b0;
      ex_q   <= 1'b0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      aw_q   <= !base_known_i;
      ex_q   <= 1'b1;
      idx_q  <= idx_i;
      addr_q <= base_known_i ? base_i + off_new : '0;
    end else if (busy_q) begin
      // late base: pick up broadcast once
      if (aw_q && bcast_i) begin
        aw_q   <= 1'b0;
        addr_q <= base_i + off_old;
      end
      if (!aw_q && mem_ok_i) ex_q <= 1'b0;
      if (!ex_q && retire_i) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign aw_o   = aw_q;
  assign ex_o   = ex_q;
  assign req_o  = busy_q && !aw_q && (!ex_q || spec_i);
  assign addr_o = addr_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/ld_base_bcast.sv
module ld_base_bcast
  import lbb_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vec_start_i,
  input  logic [1:0]                    vec_size_i,
  input  logic                          vec_spec_i,
  input  logic                          issue_valid_i,
  input  logic [IDX_W-1:0]              issue_idx_i,
  output logic                          issue_ready_o,
  input  logic                          base_valid_i,
  input  logic [ADDR_W-1:0]             base_addr_i,
  input  logic [NUM_UNITS-1:0]          mem_ok_i,
  input  logic [NUM_UNITS-1:0]          retire_i,
  input  logic [NUM_UNITS-1:0]          fault_i,
  output logic [NUM_UNITS-1:0]          unit_busy_o,
  output logic [NUM_UNITS-1:0]          unit_aw_o,
  output logic [NUM_UNITS-1:0]          unit_ex_o,
  output logic [NUM_UNITS-1:0]          unit_req_o,
  output logic [NUM_UNITS*ADDR_W-1:0]   unit_addr_o,
  output logic [NUM_UNITS*IDX_W-1:0]    unit_idx_o,
  output logic                          fault_valid_o,
  output logic [IDX_W-1:0]              fault_idx_o
);
  esize_e            size_q;
  logic              spec_q;
  logic [ADDR_W-1:0] base_q;
  logic              base_vld_q;
  logic              lock_q;
  logic              fault_vld_q;
  logic [IDX_W-1:0]  fault_idx_q;

  logic [NUM_UNITS-1:0] free_gnt, alloc, kill, fault_hit;
  logic                 any_free, f_any, alloc_go, base_take, base_known;
  logic [IDX_W-1:0]     f_idx;
  logic [ADDR_W-1:0]    base_eff;

  assign fault_hit = vec_start_i ? '0 : (fault_i & unit_busy_o & ~unit_aw_o);

  lbb_oldest #(.N(NUM_UNITS), .IDX_W(IDX_W)) u_oldest (
    .hit_i (fault_hit),
    .idx_i (unit_idx_o),
    .any_o (f_any),
    .idx_o (f_idx)
  );

  lbb_pick_low #(.N(NUM_UNITS)) u_pick (
    .req_i (~unit_busy_o),
    .gnt_o (free_gnt),
    .any_o (any_free)
  );

  assign issue_ready_o = !lock_q && any_free && !f_any && !vec_start_i;
  assign alloc_go      = issue_valid_i && issue_ready_o;
  assign base_take     = base_valid_i && !base_vld_q && !vec_start_i;
  assign base_known    = base_vld_q || base_take;
  assign base_eff      = base_vld_q ? base_q : base_addr_i;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    assign alloc[k] = alloc_go && free_gnt[k];
    assign kill[k]  = vec_start_i ||
                      (f_any && unit_busy_o[k] && (unit_idx_o[k*IDX_W +: IDX_W] >= f_idx));

    lbb_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_unit (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (alloc[k]),
      .idx_i        (issue_idx_i),
      .size_i       (size_q),
      .base_known_i (base_known),
      .base_i       (base_eff),
      .bcast_i      (base_take),
      .mem_ok_i     (mem_ok_i[k]),
      .retire_i     (retire_i[k]),
      .kill_i       (kill[k]),
      .spec_i       (spec_q),
      .busy_o       (unit_busy_o[k]),
      .aw_o         (unit_aw_o[k]),
      .ex_o         (unit_ex_o[k]),
      .req_o        (unit_req_o[k]),
      .addr_o       (unit_addr_o[k*ADDR_W +: ADDR_W]),
      .idx_o        (unit_idx_o[k*IDX_W +: IDX_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q      <= ESZ_BYTE;
      spec_q      <= 1'b0;
      base_q      <= '0;
      base_vld_q  <= 1'b0;
      lock_q      <= 1'b0;
      fault_vld_q <= 1'b0;
      fault_idx_q <= '0;
    end else if (vec_start_i) begin
      size_q      <= esize_e'(vec_size_i);
      spec_q      <= vec_spec_i;
      base_vld_q  <= 1'b0;
      lock_q      <= 1'b0;
      fault_vld_q <= 1'b0;
    end else begin
      if (base_take) begin
        base_q     <= base_addr_i;
        base_vld_q <= 1'b1;
      end
      fault_vld_q <= f_any;
      if (f_any) begin
        fault_idx_q <= f_idx;
        lock_q      <= 1'b1;
      end
    end
  end

  assign fault_valid_o = fault_vld_q;
  assign fault_idx_o   = fault_idx_q;
endmodule

// File: rtl/lbb_shadow_chk.sv
module lbb_shadow_chk #(
  parameter int unsigned NUM_UNITS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 vec_start_i,
  input logic                 base_valid_i,
  input logic [NUM_UNITS-1:0] mem_ok_i,
  input logic [NUM_UNITS-1:0] fault_i,
  input logic                 issue_ready_o,
  input logic [NUM_UNITS-1:0] unit_busy_o,
  input logic [NUM_UNITS-1:0] unit_aw_o,
  input logic [NUM_UNITS-1:0] unit_ex_o,
  input logic [NUM_UNITS-1:0] unit_req_o,
  input logic                 fault_valid_o
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (unit_busy_o == '0 && !fault_valid_o));

  assert_req_needs_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_req_o & (~unit_busy_o | unit_aw_o)) == '0);

  assert_bcast_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_valid_i && !vec_start_i) |=> (unit_aw_o == '0));

  assert_ex_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_start_i && fault_i == '0) |=>
      (($past(unit_busy_o & unit_ex_o & ~mem_ok_i) & ~unit_ex_o) == '0));

  assert_retire_blocked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_start_i && fault_i == '0) |=>
      (($past(unit_busy_o & unit_ex_o) & ~unit_busy_o) == '0));

  assert_full_refuses_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&unit_busy_o) |-> !issue_ready_o);

  assert_one_alloc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(unit_busy_o & ~$past(unit_busy_o)) <= 1));

  assert_fault_locks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |-> !issue_ready_o);
endmodule

bind ld_base_bcast lbb_shadow_chk #(.NUM_UNITS(NUM_UNITS)) u_shadow_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .vec_start_i   (vec_start_i),
  .base_valid_i  (base_valid_i),
  .mem_ok_i      (mem_ok_i),
  .fault_i       (fault_i),
  .issue_ready_o (issue_ready_o),
  .unit_busy_o   (unit_busy_o),
  .unit_aw_o     (unit_aw_o),
  .unit_ex_o     (unit_ex_o),
  .unit_req_o    (unit_req_o),
  .fault_valid_o (fault_valid_o)
);

// File: tb/ld_base_bcast_test.sv
module ld_base_bcast_test;
  localparam int NU = 4;
  localparam int AW = 32;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          d_vs = 0, d_spec_in = 0, d_iv = 0, d_bv = 0;
  logic [1:0]    d_size = 0;
  logic [IW-1:0] d_ii = 0;
  logic [AW-1:0] d_bd = 0;
  logic [NU-1:0] d_mok = 0, d_ret = 0, d_flt = 0;

  logic             rdy, fv;
  logic [NU-1:0]    busy, aw, ex, req;
  logic [NU*AW-1:0] addr;
  logic [NU*IW-1:0] idxs;
  logic [IW-1:0]    fidx;

  ld_base_bcast #(.NUM_UNITS(NU), .ADDR_W(AW), .IDX_W(IW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .vec_start_i(d_vs), .vec_size_i(d_size), .vec_spec_i(d_spec_in),
    .issue_valid_i(d_iv), .issue_idx_i(d_ii), .issue_ready_o(rdy),
    .base_valid_i(d_bv), .base_addr_i(d_bd),
    .mem_ok_i(d_mok), .retire_i(d_ret), .fault_i(d_flt),
    .unit_busy_o(busy), .unit_aw_o(aw), .unit_ex_o(ex), .unit_req_o(req),
    .unit_addr_o(addr), .unit_idx_o(idxs),
    .fault_valid_o(fv), .fault_idx_o(fidx)
  );

  int total = 0, bad = 0;

  // reference state
  bit            m_busy[NU], m_aw[NU], m_ex[NU];
  logic [IW-1:0] m_idx[NU];
  logic [AW-1:0] m_addr[NU];
  logic [AW-1:0] m_base = 0;
  bit            m_bvld = 0, m_lock = 0, m_fv = 0, m_spec = 0, m_rdy = 0;
  logic [IW-1:0] m_fidx = 0;
  logic [1:0]    m_size = 0;

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [IW-1:0] i, logic [1:0] s);
    return b + AW'(i) * (AW'(1) << s);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(output bit acc);
    bit fany = 0; logic [IW-1:0] fi = '0; int g = -1; bit take; bit oaw, oex;
    acc = 0;
    if (d_vs) begin
      for (int k = 0; k < NU; k++) begin m_busy[k] = 0; m_aw[k] = 0; m_ex[k] = 0; end
      m_bvld = 0; m_lock = 0; m_fv = 0; m_size = d_size; m_spec = d_spec_in; m_rdy = 0;
      return;
    end
    for (int k = 0; k < NU; k++)
      if (d_flt[k] && m_busy[k] && !m_aw[k] && (!fany || m_idx[k] < fi)) begin
        fany = 1; fi = m_idx[k];
      end
    for (int k = NU-1; k >= 0; k--) if (!m_busy[k]) g = k;
    m_rdy = !m_lock && g >= 0 && !fany;
    acc = d_iv && m_rdy;
    take = d_bv && !m_bvld;
    for (int k = 0; k < NU; k++) begin
      if (fany && m_busy[k] && m_idx[k] >= fi) begin
        m_busy[k] = 0; m_aw[k] = 0; m_ex[k] = 0;
      end else if (m_busy[k]) begin
        oaw = m_aw[k]; oex = m_ex[k];
        if (oaw && take) begin m_aw[k] = 0; m_addr[k] = exp_addr(d_bd, m_idx[k], m_size); end
        if (!oaw && d_mok[k]) m_ex[k] = 0;
        if (!oex && d_ret[k]) m_busy[k] = 0;
      end else if (acc && k == g) begin
        m_busy[k] = 1; m_ex[k] = 1; m_idx[k] = d_ii;
        m_aw[k] = !(m_bvld || take);
        m_addr[k] = m_bvld ? exp_addr(m_base, d_ii, m_size) :
                    take   ? exp_addr(d_bd, d_ii, m_size) : '0;
      end
    end
    if (take) begin m_bvld = 1; m_base = d_bd; end
    m_fv = fany;
    if (fany) begin m_fidx = fi; m_lock = 1; end
  endtask

  task automatic check_state();
    logic [NU-1:0] eb, ea, ee, er;
    for (int k = 0; k < NU; k++) begin
      eb[k] = m_busy[k]; ea[k] = m_aw[k]; ee[k] = m_ex[k];
      er[k] = m_busy[k] && !m_aw[k] && (!m_ex[k] || m_spec);
    end
    chk(busy == eb, "R9/R8/R11 busy", 64'(busy), 64'(eb));
    chk(aw == ea, "R2/R3 addr-wait", 64'(aw), 64'(ea));
    chk(ex == ee, "R4 exception shadow", 64'(ex), 64'(ee));
    chk(req == er, "R5 request", 64'(req), 64'(er));
    chk(fv == m_fv, "R10 fault valid", 64'(fv), 64'(m_fv));
    if (m_fv) chk(fidx == m_fidx, "R10 fault index", 64'(fidx), 64'(m_fidx));
    for (int k = 0; k < NU; k++)
      if (m_busy[k]) begin
        chk(idxs[k*IW +: IW] == m_idx[k], "R9 element index", 64'(idxs[k*IW +: IW]), 64'(m_idx[k]));
        if (!m_aw[k])
          chk(addr[k*AW +: AW] == m_addr[k], "R3/R6/R7 address", 64'(addr[k*AW +: AW]), 64'(m_addr[k]));
      end
  endtask

  // one cycle: drive at negedge, check ready before edge, check state at next negedge
  task automatic cyc(bit iv, logic [IW-1:0] ii, bit bv, logic [AW-1:0] bd,
                     logic [NU-1:0] mok, logic [NU-1:0] ret, logic [NU-1:0] flt, output bit acc);
    d_vs = 0; d_iv = iv; d_ii = ii; d_bv = bv; d_bd = bd; d_mok = mok; d_ret = ret; d_flt = flt;
    model_step(acc);
    #1;
    chk(rdy == m_rdy, "R8/R10 issue ready", 64'(rdy), 64'(m_rdy));
    @(negedge clk);
    check_state();
  endtask

  task automatic vstart(logic [1:0] sz, bit sp);
    bit acc;
    d_vs = 1; d_size = sz; d_spec_in = sp;
    d_iv = 0; d_bv = 0; d_mok = 0; d_ret = 0; d_flt = 0;
    model_step(acc);
    @(negedge clk);
    d_vs = 0;
    check_state();
  endtask

  initial begin
    #600000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit acc;
    int seed = 17;
    void'($urandom(seed));
    for (int k = 0; k < NU; k++) begin m_busy[k] = 0; m_aw[k] = 0; m_ex[k] = 0; m_idx[k] = 0; m_addr[k] = 0; end
    repeat (3) @(negedge clk);
    // R1
    chk(busy == '0 && aw == '0 && ex == '0 && req == '0, "R1 idle after reset", 64'(busy), 0);
    chk(fv == 1'b0, "R1 no fault after reset", 64'(fv), 0);
    chk(rdy == 1'b1, "R1 ready after reset", 64'(rdy), 1);
    rst_n = 1;
    @(negedge clk);

    // directed: word elements, base arrives late (R2, R8, R3, R7, R11, R4, R6)
    vstart(2'd2, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1, IW'(i), 0, 0, 0, 0, 0, acc);
    chk(rdy == 1'b0, "R8 pool full refuses", 64'(rdy), 0);
    cyc(1, 6'd4, 0, 0, 0, 0, 0, acc);
    chk(acc == 0, "R8 element not taken while full", 64'(acc), 0);
    cyc(0, 0, 1, 32'h1000, 0, 0, 0, acc);
    chk(addr[3*AW +: AW] == 32'h100c, "R3 broadcast address unit3", 64'(addr[3*AW +: AW]), 64'h100c);
    cyc(0, 0, 1, 32'h2000, 0, '1, 0, acc);
    chk(busy == 4'hf, "R11 retire ignored under exception shadow", 64'(busy), 64'hf);
    chk(addr[1*AW +: AW] == 32'h1004, "R7 second base ignored", 64'(addr[1*AW +: AW]), 64'h1004);
    cyc(0, 0, 0, 0, 4'b0011, 0, 0, acc);
    chk(ex == 4'b1100, "R4 only confirmed units drop exception shadow", 64'(ex), 64'hc);
    cyc(0, 0, 0, 0, 0, 4'b0011, 0, acc);
    cyc(1, 6'd4, 0, 0, 0, 0, 0, acc);
    chk(aw[0] == 1'b0 && addr[0 +: AW] == 32'h1010, "R6 late issue gets address at once",
        64'(addr[0 +: AW]), 64'h1010);
    cyc(1, 6'd5, 0, 0, 0, 0, 0, acc);
    chk(busy[1] == 1'b1, "R9 lowest free unit used", 64'(busy), 64'hf);
    cyc(0, 0, 0, 0, '1, 0, 0, acc);
    // faults on idx 6? units: u0=4 u1=5 u2=2 u3=3; fault units 1 and 3 -> oldest idx 3
    cyc(0, 0, 0, 0, 0, 0, 4'b1010, acc);
    chk(fv == 1'b1 && fidx == 6'd3, "R10 oldest fault reported", 64'(fidx), 3);
    chk(busy == 4'b0100, "R10 younger elements cancelled", 64'(busy), 64'h4);
    cyc(1, 6'd6, 0, 0, 0, 0, 0, acc);
    chk(acc == 0, "R10 issue locked after fault", 64'(acc), 0);
    cyc(0, 0, 0, 0, 0, '1, 0, acc);

    // random vectors
    for (int v = 0; v < 200; v++) begin
      int vl, nxt, n;
      vl = 1 + int'($urandom_range(11));
      nxt = 0; n = 0;
      vstart(2'($urandom_range(3)), 1'($urandom_range(1)));
      while (n < 300) begin
        bit iv, bv, idle;
        logic [NU-1:0] flt;
        idle = 1;
        for (int k = 0; k < NU; k++) if (m_busy[k]) idle = 0;
        if (idle && (nxt >= vl || m_lock)) break;
        iv = (nxt < vl) && ($urandom_range(3) != 0);
        bv = ($urandom_range(4) == 0);
        flt = ($urandom_range(24) == 0) ? NU'($urandom_range(15)) : '0;
        cyc(iv, IW'(nxt), bv, $urandom, NU'($urandom_range(15)), NU'($urandom_range(15)), flt, acc);
        if (acc) nxt++;
        n++;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule